// File: doc/BRIEF.md
# HDB3 / AMI Line Codec

This block turns a serial NRZ bit stream into a bipolar line code carried on two unipolar binary rails, one for positive marks and one for negative marks. External circuitry can combine the rails into a ternary line signal. A mode input selects plain alternate-mark-inversion coding or HDB3, which replaces every run of four zeros with a code word that contains a deliberate bipolar violation. The substitution keeps the line from going quiet for long stretches, so a clock can still be recovered from it. The same block also holds the matching decoder. The decoder takes two unipolar receive rails and turns them back into NRZ. When it works in HDB3 mode it removes each substitution.

A loop control lets a self-test run without any line. When loop is high, the encoder rails drive the decoder inside the block and the external receive rails are ignored. The recovered NRZ then repeats the input NRZ exactly 8 clocks later. A clock-recovery output reports whether either of the rails selected for the decoder carries a mark. An external clock extractor can use it.

Top module: `hdb3_line_codec`

## Requirements
- R1: While `rst` is high, and on the first edge after it, all four outputs are low. Reset leaves the encoder and the decoder both treating the last mark as negative. The first mark after reset is therefore sent and expected on `pos_out`.
- R2: With `hdb3_sel` low, an input 1 makes a mark on the rail opposite to the previous mark, and an input 0 leaves both rails low. The bit sampled on edge k appears on the rails after edge k+4.
- R3: `pos_out` and `neg_out` are never high together.
- R4: With `hdb3_sel` high, four zeros after an odd count of marks since the last violation are sent as 0,0,0,V. V is a mark with the same polarity as the mark before it.
- R5: With `hdb3_sel` high, four zeros after an even count of marks since the last violation (the count starts at zero after reset) are sent as B,0,0,V. B obeys the alternation rule, and V repeats the polarity of B.
- R6: With `hdb3_sel` high, a stream that never holds four zeros in a row is coded exactly as in R2.
- R7: With `hdb3_sel` low, the decoder outputs 1 for every mark on either rail and 0 otherwise. A rail pair sampled on edge j appears on `nrz_out` after edge j+3.
- R8: With `hdb3_sel` high, a received mark whose polarity equals the previous received mark is a violation. The decoder outputs 0 for it and for the three bit times before it, and otherwise follows R7.
- R9: With `loop_en` high, the decoder reads the encoder rails, `rx_pos_in` and `rx_neg_in` have no effect, and `nrz_out` after edge k+8 equals `nrz_in` sampled on edge k.
- R10: After each edge, `rclk_out` is the OR of the two rails the decoder sampled on that edge. Those are the external rails when `loop_en` is low, and the values of `pos_out` and `neg_out` present at the edge when it is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both transmit and receive |
| rst | input | 1 | Synchronous active-high reset |
| nrz_in | input | 1 | Serial NRZ data to encode |
| hdb3_sel | input | 1 | 1 = HDB3 substitution, 0 = plain AMI (both directions) |
| loop_en | input | 1 | 1 = decoder fed from encoder rails |
| rx_pos_in | input | 1 | External positive-mark receive rail |
| rx_neg_in | input | 1 | External negative-mark receive rail |
| pos_out | output | 1 | Positive-mark transmit rail |
| neg_out | output | 1 | Negative-mark transmit rail |
| rclk_out | output | 1 | OR of the selected receive rails, registered |
| nrz_out | output | 1 | Decoded NRZ data |

## Verification
The first stream holds only zeros, so the output is B00V repeated from reset onwards. That pattern separates parity bookkeeping and the reset polarity from plain alternation. A sparse stream with zero runs from zero to nine, each run after an odd or an even count of ones, sets the 000V and B00V choices apart and also exercises runs that straddle a substitution. A dense stream with no four-zero run, sent in HDB3 mode, has to match AMI exactly. Separate passes drive the receive rails directly with HDB3 symbols: one decodes them in HDB3 mode, and one decodes them in AMI mode, where every violation must come out as a 1. Random values on the external rails during the loop passes show that those rails are ignored.

// File: rtl/hdb3_pkg.sv
package hdb3_pkg;

  // Length of the zero run that HDB3 replaces.
  localparam int RUN_LEN = 4;

  // Symbol kinds held in the encoder lookahead pipeline.
  typedef enum logic [1:0] {
    SYM_ZERO = 2'd0,
    SYM_ONE  = 2'd1,
    SYM_BPAD = 2'd2,
    SYM_VIOL = 2'd3
  } sym_kind_t;

endpackage

// File: rtl/hdb3_tx_coder.sv
module hdb3_tx_coder
  import hdb3_pkg::*;
#(
  parameter int RUN_LEN = hdb3_pkg::RUN_LEN
) (
  input  logic clk,
  input  logic rst,
  input  logic nrz_in,
  input  logic hdb3_sel,
  output logic pos_out,
  output logic neg_out
);

  localparam int LAST = RUN_LEN - 1;

  sym_kind_t slot_q [RUN_LEN];   // index 0 newest, LAST oldest
  sym_kind_t slot_d [RUN_LEN];
  logic      lastp_q;            // 1: last mark positive
  logic      par_q;              // odd marks since last violation
  logic      par_after;
  logic      lastp_after;
  logic      head_mark;
  logic      run_zero;

  always_comb begin
    head_mark   = (slot_q[LAST] != SYM_ZERO);
    par_after   = par_q;
    lastp_after = lastp_q;
    unique case (slot_q[LAST])
      SYM_ONE, SYM_BPAD: begin
        par_after   = ~par_q;
        lastp_after = ~lastp_q;
      end
      SYM_VIOL: begin
        par_after   = 1'b0;
        lastp_after = lastp_q;
      end
      default: ;
    endcase

    run_zero = hdb3_sel && !nrz_in;
    for (int k = 0; k < LAST; k++) begin
      run_zero = run_zero && (slot_q[k] == SYM_ZERO);
    end

    slot_d[0] = run_zero ? SYM_VIOL : (nrz_in ? SYM_ONE : SYM_ZERO);
    for (int k = 1; k < RUN_LEN; k++) begin
      slot_d[k] = slot_q[k-1];
    end
    if (run_zero) begin
      slot_d[LAST] = par_after ? SYM_ZERO : SYM_BPAD;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < RUN_LEN; k++) begin
        slot_q[k] <= SYM_ZERO;
      end
      lastp_q <= 1'b0;
      par_q   <= 1'b0;
      pos_out <= 1'b0;
      neg_out <= 1'b0;
    end else begin
      for (int k = 0; k < RUN_LEN; k++) begin
        slot_q[k] <= slot_d[k];
      end
      lastp_q <= lastp_after;
      par_q   <= par_after;
      pos_out <= head_mark && lastp_after;
      neg_out <= head_mark && !lastp_after;
    end
  end

  // R3
  rails_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(pos_out && neg_out));

  // R2
  ami_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(hdb3_sel, 1) && !$past(hdb3_sel, 2) && !$past(hdb3_sel, 3) &&
     !$past(hdb3_sel, 4) && !$past(hdb3_sel, 5) && !$past(nrz_in, 5))
    |-> (!pos_out && !neg_out));

endmodule

// File: rtl/hdb3_rx_decoder.sv
module hdb3_rx_decoder #(
  parameter int RUN_LEN = hdb3_pkg::RUN_LEN
) (
  input  logic clk,
  input  logic rst,
  input  logic hdb3_sel,
  input  logic in_pos,
  input  logic in_neg,
  output logic nrz_out
);

  localparam int DEPTH = RUN_LEN - 1;

  logic [DEPTH-1:0] win_q;    // bit 0 newest
  logic             lastp_q;  // 1: last received mark positive
  logic             mark;
  logic             viol;

  always_comb begin
    mark = in_pos || in_neg;
    viol = hdb3_sel && mark && (in_pos == lastp_q);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      win_q   <= '0;
      lastp_q <= 1'b0;
      nrz_out <= 1'b0;
    end else begin
      if (viol) begin
        win_q   <= '0;
        nrz_out <= 1'b0;
      end else begin
        win_q   <= {win_q[DEPTH-2:0], mark};
        nrz_out <= win_q[DEPTH-1];
      end
      if (mark) begin
        lastp_q <= in_pos;
      end
    end
  end

  // R7
  dec_mark_src_chk: assert property (@(posedge clk) disable iff (rst)
    nrz_out |-> $past(in_pos || in_neg, 4));

endmodule

// File: rtl/hdb3_rail_select.sv
module hdb3_rail_select (
  input  logic clk,
  input  logic rst,
  input  logic loop_en,
  input  logic tx_pos,
  input  logic tx_neg,
  input  logic rx_pos,
  input  logic rx_neg,
  output logic sel_pos,
  output logic sel_neg,
  output logic rclk_out
);

  always_comb begin
    sel_pos = loop_en ? tx_pos : rx_pos;
    sel_neg = loop_en ? tx_neg : rx_neg;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rclk_out <= 1'b0;
    end else begin
      rclk_out <= sel_pos || sel_neg;
    end
  end

  // R10
  rclk_src_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(rclk_out) |-> $past(tx_pos || tx_neg || rx_pos || rx_neg));

endmodule

// File: rtl/hdb3_line_codec.sv
module hdb3_line_codec #(
  parameter int RUN_LEN = hdb3_pkg::RUN_LEN
) (
  input  logic clk,
  input  logic rst,
  input  logic nrz_in,
  input  logic hdb3_sel,
  input  logic loop_en,
  input  logic rx_pos_in,
  input  logic rx_neg_in,
  output logic pos_out,
  output logic neg_out,
  output logic rclk_out,
  output logic nrz_out
);

  localparam int LOOP_LAT = 2 * RUN_LEN;

  logic sel_pos;
  logic sel_neg;

  hdb3_tx_coder #(.RUN_LEN(RUN_LEN)) u_tx (
    .clk      (clk),
    .rst      (rst),
    .nrz_in   (nrz_in),
    .hdb3_sel (hdb3_sel),
    .pos_out  (pos_out),
    .neg_out  (neg_out)
  );

  hdb3_rail_select u_sel (
    .clk      (clk),
    .rst      (rst),
    .loop_en  (loop_en),
    .tx_pos   (pos_out),
    .tx_neg   (neg_out),
    .rx_pos   (rx_pos_in),
    .rx_neg   (rx_neg_in),
    .sel_pos  (sel_pos),
    .sel_neg  (sel_neg),
    .rclk_out (rclk_out)
  );

  hdb3_rx_decoder #(.RUN_LEN(RUN_LEN)) u_rx (
    .clk      (clk),
    .rst      (rst),
    .hdb3_sel (hdb3_sel),
    .in_pos   (sel_pos),
    .in_neg   (sel_neg),
    .nrz_out  (nrz_out)
  );

  // Check-only tracking: loop held with a fixed mode since reset.
  logic [4:0] warm_q;
  logic       clean_q;
  logic       mode_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      warm_q  <= '0;
      clean_q <= 1'b1;
      mode_q  <= hdb3_sel;
    end else begin
      if (!loop_en || hdb3_sel != mode_q) begin
        clean_q <= 1'b0;
      end
      if (warm_q != 5'd31) begin
        warm_q <= warm_q + 5'd1;
      end
    end
  end

  // R9
  loop_delay_chk: assert property (@(posedge clk) disable iff (rst)
    (clean_q && loop_en && hdb3_sel == mode_q && warm_q >= 5'(LOOP_LAT + 1))
    |-> (nrz_out == $past(nrz_in, 9)));

endmodule

// File: tb/sim_hdb3_line_codec.sv
module sim_hdb3_line_codec;

  localparam int MAXN = 700;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic nrz_in = 1'b0;
  logic hdb3_sel = 1'b0;
  logic loop_en = 1'b0;
  logic rx_pos_in = 1'b0;
  logic rx_neg_in = 1'b0;
  logic pos_out, neg_out, rclk_out, nrz_out;

  int total = 0;
  int bad = 0;
  int bits [MAXN];
  int src  [MAXN];
  int sym  [MAXN];

  always #2 clk = ~clk;

  hdb3_line_codec u0 (
    .clk      (clk),
    .rst      (rst),
    .nrz_in   (nrz_in),
    .hdb3_sel (hdb3_sel),
    .loop_en  (loop_en),
    .rx_pos_in(rx_pos_in),
    .rx_neg_in(rx_neg_in),
    .pos_out  (pos_out),
    .neg_out  (neg_out),
    .rclk_out (rclk_out),
    .nrz_out  (nrz_out)
  );

  task automatic chk(input string tag, input int act, input int exp, input int edge_no);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s edge=%0d actual=%0d expected=%0d", tag, edge_no, act, exp);
    end
  endtask

  function automatic int rails();
    if (pos_out && neg_out) return 2;
    if (pos_out) return 1;
    if (neg_out) return -1;
    return 0;
  endfunction

  // Behavioural line coder over src[0..n-1]; positions before 'first' send 0.
  task automatic model_encode(input int n, input int first, input bit sub);
    int lastpol;
    int par;
    int i;
    lastpol = -1;
    par = 0;
    for (int k = 0; k < n; k++) sym[k] = 0;
    i = first;
    while (i < n) begin
      if (sub && i + 3 < n && src[i] == 0 && src[i+1] == 0 &&
          src[i+2] == 0 && src[i+3] == 0) begin
        if (par % 2 == 0) begin
          lastpol = -lastpol;
          sym[i] = lastpol;
        end
        sym[i+3] = lastpol;
        par = 0;
        i += 4;
      end else if (src[i] != 0) begin
        lastpol = -lastpol;
        sym[i] = lastpol;
        par++;
        i++;
      end else begin
        i++;
      end
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    nrz_in = 1'b0;
    rx_pos_in = 1'b0;
    rx_neg_in = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: outputs idle during reset
    chk("R1 pos_out", pos_out, 0, -1);
    chk("R1 neg_out", neg_out, 0, -1);
    chk("R1 rclk_out", rclk_out, 0, -1);
    chk("R1 nrz_out", nrz_out, 0, -1);
    rst = 1'b0;
  endtask

  // Loop test: DUT encodes bits[], decoder reads its rails internally.
  task automatic run_loop(input bit dut_sub, input bit model_sub, input int n,
                          input string rail_tag);
    for (int k = 0; k < 4; k++) src[k] = 0;
    for (int k = 0; k < n; k++) src[k+4] = bits[k];
    model_encode(n + 4, 1, model_sub);
    hdb3_sel = dut_sub;
    loop_en = 1'b1;
    do_reset();
    for (int e = 0; e < n; e++) begin
      nrz_in = bits[e][0];
      rx_pos_in = 1'($urandom % 2);
      rx_neg_in = 1'($urandom % 2);
      @(posedge clk);
      @(negedge clk);
      chk(rail_tag, rails(), sym[e], e);
      // R3
      chk("R3 rails exclusive", int'(pos_out && neg_out), 0, e);
      // R9
      chk("R9 loop nrz", int'(nrz_out), (e >= 8) ? bits[e-8] : 0, e);
      // R10
      chk("R10 rclk loop", int'(rclk_out), (e >= 1) ? int'(sym[e-1] != 0) : 0, e);
    end
  endtask

  // External receive: rails driven from HDB3 symbols of bits[].
  task automatic run_ext(input bit dec_sub, input int n, input string nrz_tag);
    for (int k = 0; k < n; k++) src[k] = bits[k];
    model_encode(n, 0, 1'b1);
    hdb3_sel = dec_sub;
    loop_en = 1'b0;
    do_reset();
    for (int e = 0; e < n; e++) begin
      nrz_in = 1'($urandom % 2);
      rx_pos_in = (sym[e] == 1);
      rx_neg_in = (sym[e] == -1);
      @(posedge clk);
      @(negedge clk);
      if (e >= 3) begin
        chk(nrz_tag, int'(nrz_out),
            dec_sub ? bits[e-3] : int'(sym[e-3] != 0), e);
      end else begin
        chk(nrz_tag, int'(nrz_out), 0, e);
      end
      // R10
      chk("R10 rclk ext", int'(rclk_out), int'(sym[e] != 0), e);
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    // R2 with R9, R10: random dense stream in AMI
    for (int k = 0; k < 120; k++) bits[k] = int'($urandom % 2);
    run_loop(1'b0, 1'b0, 120, "R2 ami rails");

    // R5 and R1: all zeros in HDB3, B00V from reset, first mark positive
    for (int k = 0; k < 40; k++) bits[k] = 0;
    run_loop(1'b1, 1'b1, 40, "R5 R1 zero stream rails");

    // R4 and R5: zero runs of 0..9 after odd and even mark counts
    begin
      int p;
      p = 0;
      for (int r = 0; r < 10; r++) begin
        for (int ones = 1; ones <= 2; ones++) begin
          for (int q = 0; q < ones; q++) begin bits[p] = 1; p++; end
          for (int z = 0; z < r; z++) begin bits[p] = 0; p++; end
        end
      end
      for (int k = 0; k < 60; k++) begin
        bits[p] = int'($urandom % 4 == 0);
        p++;
      end
      run_loop(1'b1, 1'b1, p, "R4 R5 run rails");
    end

    // R6: HDB3 mode with no four-zero run codes as AMI
    for (int k = 0; k < 150; k++) bits[k] = (k % 4 == 0) ? 1 : int'($urandom % 2);
    run_loop(1'b1, 1'b0, 150, "R6 short run rails");

    // R8: external HDB3 line decoded in HDB3 mode
    for (int k = 0; k < 200; k++) bits[k] = int'($urandom % 3 == 0);
    run_ext(1'b1, 200, "R8 hdb3 decode");

    // R7: same kind of line decoded in AMI mode, violations count as ones
    for (int k = 0; k < 200; k++) bits[k] = int'($urandom % 3 == 0);
    run_ext(1'b0, 200, "R7 ami decode");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule